// File: doc/BRIEF.md
# Victim Cache Buffer

A small fully associative store of cache lines that sits behind a direct-mapped first-level cache. It keeps lines the first-level cache has just displaced. Two addresses that share a first-level slot can then alternate without each reuse going out to the next memory level. The buffer is searched only after a first-level miss, so the first-level hit path does not pass through it. Each entry holds a full line address, a valid flag, a dirty flag and the line data.

One request can carry a lookup address, the line the first-level cache is displacing, or both. The result comes back one cycle later. On a hit, the buffer returns the stored line together with its dirty flag. The displaced line then takes over the slot that was hit, so the two lines swap places. On a miss, the address is forwarded on the next-level miss output, and the displaced line is inserted in round-robin order. A dirty line pushed out by that insertion leaves on the writeback output. An eviction can also be presented without any lookup.

Top module: `victim_buf`

## Requirements
- R1: After reset every entry is invalid, the insertion pointer names slot 0, and rsp_valid_o, rsp_hit_o, miss_valid_o and wb_valid_o are low.
- R2: A lookup sampled with req_valid_i high gives rsp_valid_o high exactly one cycle later. rsp_hit_o is high when a valid entry holds the request address. On a hit, rsp_data_o and rsp_dirty_o carry that entry's contents as they stood before the same edge's update.
- R3: On a lookup miss, miss_valid_o is high in the response cycle and miss_addr_o equals the request address. On a hit, miss_valid_o stays low.
- R4: A hit that comes with an eviction writes the evicted line (address, data, dirty flag) into the slot that hit, so the hit address leaves the buffer. A hit without an eviction frees that slot.
- R5: An eviction that neither hits nor matches a stored address is written to the slot named by a pointer. The pointer starts at 0 and steps by one per such insertion, wrapping from ENTRIES-1 to 0. Swaps and merges leave it unchanged.
- R6: When an insertion under R5 overwrites a valid dirty entry, wb_valid_o is high one cycle later with that entry's address on wb_addr_o and its data on wb_data_o. A clean or invalid entry that is overwritten is dropped without a writeback.
- R7: No two valid entries ever hold the same address. An eviction whose address is already stored replaces that entry in place, with its dirty flag set to the OR of the old and new flags. No writeback follows and the pointer does not move. If the same cycle's lookup hit a different slot, that slot is freed.
- R8: An eviction with req_valid_i low performs its insertion and produces no response (rsp_valid_o and miss_valid_o stay low).
- R9: Address matching uses all ADDR_W bits. Addresses that differ only in the top bit do not match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Lookup request after a first-level miss |
| req_addr_i | input | ADDR_W | Line address looked up |
| evict_valid_i | input | 1 | A displaced first-level line is presented |
| evict_addr_i | input | ADDR_W | Address of the displaced line |
| evict_data_i | input | DATA_W | Data of the displaced line |
| evict_dirty_i | input | 1 | Displaced line is modified |
| rsp_valid_o | output | 1 | Lookup result valid |
| rsp_hit_o | output | 1 | Lookup found the line |
| rsp_data_o | output | DATA_W | Line returned on a hit |
| rsp_dirty_o | output | 1 | Dirty flag of the returned line |
| miss_valid_o | output | 1 | Lookup missed; request goes to the next level |
| miss_addr_o | output | ADDR_W | Address forwarded to the next level |
| wb_valid_o | output | 1 | Dirty line pushed out for writeback |
| wb_addr_o | output | ADDR_W | Address of the written-back line |
| wb_data_o | output | DATA_W | Data of the written-back line |

## Verification
Directed sequences first fill all slots and then overflow them with clean lines and with dirty lines. This separates silent drops from writebacks and confirms that the FIFO order starts at slot 0. Two addresses are made to ping-pong through swaps, which shows that a hit hands the line back while the pointer stays put. Other directed cases repeat an already stored address as an eviction, and look up an address that differs only in its top bit. These isolate the duplicate-merge rule and full-width matching. Constrained random traffic then draws from a small address pool, so hits, misses, merges and overflows all occur often and mix within the same cycles.

// File: rtl/victim_buf_pkg.sv
package victim_buf_pkg;
  typedef enum logic [1:0] {
    INS_NONE,
    INS_MERGE,
    INS_SWAP,
    INS_FIFO
  } ins_kind_e;
endpackage

// File: rtl/vb_match.sv
module vb_match #(
  parameter int ADDR_W  = 26,
  parameter int ENTRIES = 4
) (
  input  logic [ENTRIES-1:0]             valid_i,
  input  logic [ENTRIES-1:0][ADDR_W-1:0] tags_i,
  input  logic [ADDR_W-1:0]              addr_i,
  output logic [ENTRIES-1:0]             hit_o
);
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign hit_o[g] = valid_i[g] && (tags_i[g] == addr_i);
  end
endmodule

// File: rtl/vb_pick.sv
module vb_pick #(
  parameter int ENTRIES = 4,
  parameter int IDX_W   = 2
) (
  input  logic [ENTRIES-1:0] vec_i,
  output logic               any_o,
  output logic [IDX_W-1:0]   idx_o
);
  always_comb begin
    any_o = |vec_i;
    idx_o = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (vec_i[i]) idx_o = IDX_W'(i);
    end
  end
endmodule

// File: rtl/vb_store.sv
module vb_store #(
  parameter int ADDR_W  = 26,
  parameter int DATA_W  = 64,
  parameter int ENTRIES = 4,
  parameter int IDX_W   = 2
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           wr_en_i,
  input  logic [IDX_W-1:0]               wr_idx_i,
  input  logic [ADDR_W-1:0]              wr_addr_i,
  input  logic [DATA_W-1:0]              wr_data_i,
  input  logic                           wr_dirty_i,
  input  logic                           clr_en_i,
  input  logic [IDX_W-1:0]               clr_idx_i,
  output logic [ENTRIES-1:0]             valid_o,
  output logic [ENTRIES-1:0]             dirty_o,
  output logic [ENTRIES-1:0][ADDR_W-1:0] tag_o,
  output logic [ENTRIES-1:0][DATA_W-1:0] data_o
);
  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    logic wr_here, clr_here;
    assign wr_here  = wr_en_i && (wr_idx_i == IDX_W'(g));
    assign clr_here = clr_en_i && (clr_idx_i == IDX_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_o[g] <= 1'b0;
        dirty_o[g] <= 1'b0;
        tag_o[g]   <= '0;
        data_o[g]  <= '0;
      end else if (wr_here) begin
        valid_o[g] <= 1'b1;
        dirty_o[g] <= wr_dirty_i;
        tag_o[g]   <= wr_addr_i;
        data_o[g]  <= wr_data_i;
      end else if (clr_here) begin
        valid_o[g] <= 1'b0;
        dirty_o[g] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/victim_buf.sv
module victim_buf
  import victim_buf_pkg::*;
#(
  parameter int ADDR_W  = 26,
  parameter int DATA_W  = 64,
  parameter int ENTRIES = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic              evict_valid_i,
  input  logic [ADDR_W-1:0] evict_addr_i,
  input  logic [DATA_W-1:0] evict_data_i,
  input  logic              evict_dirty_i,
  output logic              rsp_valid_o,
  output logic              rsp_hit_o,
  output logic [DATA_W-1:0] rsp_data_o,
  output logic              rsp_dirty_o,
  output logic              miss_valid_o,
  output logic [ADDR_W-1:0] miss_addr_o,
  output logic              wb_valid_o,
  output logic [ADDR_W-1:0] wb_addr_o,
  output logic [DATA_W-1:0] wb_data_o
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  logic [ENTRIES-1:0]             ent_valid, ent_dirty;
  logic [ENTRIES-1:0][ADDR_W-1:0] ent_tag;
  logic [ENTRIES-1:0][DATA_W-1:0] ent_data;

  logic [ENTRIES-1:0] req_match, ev_match;
  logic               hit_any, dup_any;
  logic [IDX_W-1:0]   hit_idx, dup_idx;

  logic [IDX_W-1:0] ptr_q;
  ins_kind_e        kind;
  logic             lookup_hit, wr_en, wr_dirty, clr_en, wb_fire;
  logic [IDX_W-1:0] wr_idx;

  vb_match #(.ADDR_W(ADDR_W), .ENTRIES(ENTRIES)) u_req_match (
    .valid_i(ent_valid), .tags_i(ent_tag), .addr_i(req_addr_i), .hit_o(req_match)
  );
  vb_match #(.ADDR_W(ADDR_W), .ENTRIES(ENTRIES)) u_ev_match (
    .valid_i(ent_valid), .tags_i(ent_tag), .addr_i(evict_addr_i), .hit_o(ev_match)
  );
  vb_pick #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_hit_pick (
    .vec_i(req_match), .any_o(hit_any), .idx_o(hit_idx)
  );
  vb_pick #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_dup_pick (
    .vec_i(ev_match), .any_o(dup_any), .idx_o(dup_idx)
  );

  // Insertion policy: merge with a stored copy, else swap into hit slot, else FIFO slot
  always_comb begin
    lookup_hit = req_valid_i && hit_any;
    kind       = INS_NONE;
    if (evict_valid_i) begin
      if (dup_any)         kind = INS_MERGE;
      else if (lookup_hit) kind = INS_SWAP;
      else                 kind = INS_FIFO;
    end
    wr_en = (kind != INS_NONE);
    unique case (kind)
      INS_MERGE: wr_idx = dup_idx;
      INS_SWAP:  wr_idx = hit_idx;
      default:   wr_idx = ptr_q;
    endcase
    wr_dirty = evict_dirty_i || ((kind == INS_MERGE) && ent_dirty[dup_idx]);
    clr_en   = lookup_hit && !(wr_en && (wr_idx == hit_idx));
    wb_fire  = (kind == INS_FIFO) && ent_valid[ptr_q] && ent_dirty[ptr_q];
  end

  vb_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en),
    .wr_idx_i  (wr_idx),
    .wr_addr_i (evict_addr_i),
    .wr_data_i (evict_data_i),
    .wr_dirty_i(wr_dirty),
    .clr_en_i  (clr_en),
    .clr_idx_i (hit_idx),
    .valid_o   (ent_valid),
    .dirty_o   (ent_dirty),
    .tag_o     (ent_tag),
    .data_o    (ent_data)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
    end else if (kind == INS_FIFO) begin
      ptr_q <= (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o  <= 1'b0;
      rsp_hit_o    <= 1'b0;
      rsp_data_o   <= '0;
      rsp_dirty_o  <= 1'b0;
      miss_valid_o <= 1'b0;
      miss_addr_o  <= '0;
      wb_valid_o   <= 1'b0;
      wb_addr_o    <= '0;
      wb_data_o    <= '0;
    end else begin
      rsp_valid_o  <= req_valid_i;
      rsp_hit_o    <= lookup_hit;
      rsp_data_o   <= lookup_hit ? ent_data[hit_idx] : '0;
      rsp_dirty_o  <= lookup_hit && ent_dirty[hit_idx];
      miss_valid_o <= req_valid_i && !hit_any;
      if (req_valid_i) miss_addr_o <= req_addr_i;
      wb_valid_o   <= wb_fire;
      if (wb_fire) begin
        wb_addr_o <= ent_tag[ptr_q];
        wb_data_o <= ent_data[ptr_q];
      end
    end
  end
endmodule

// File: rtl/vb_checker.sv
module vb_checker #(
  parameter int ADDR_W  = 26,
  parameter int ENTRIES = 4
) (
  input logic                           clk_i,
  input logic                           rst_ni,
  input logic                           req_valid_i,
  input logic [ADDR_W-1:0]              req_addr_i,
  input logic                           evict_valid_i,
  input logic                           rsp_valid_o,
  input logic                           rsp_hit_o,
  input logic                           miss_valid_o,
  input logic [ADDR_W-1:0]              miss_addr_o,
  input logic                           wb_valid_o,
  input logic [ENTRIES-1:0]             ent_valid,
  input logic [ENTRIES-1:0][ADDR_W-1:0] ent_tag
);
  assert_rsp_follows_req_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o);

  assert_no_rsp_without_req_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !rsp_valid_o && !miss_valid_o);

  assert_miss_on_no_hit_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !rsp_hit_o) |-> miss_valid_o);

  assert_miss_addr_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    miss_valid_o |-> (rsp_valid_o && !rsp_hit_o && miss_addr_o == $past(req_addr_i)));

  assert_wb_needs_evict_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_valid_o |-> $past(evict_valid_i));

  for (genvar i = 0; i < ENTRIES; i++) begin : g_i
    for (genvar j = i + 1; j < ENTRIES; j++) begin : g_j
      assert_no_dup_addr_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(ent_valid[i] && ent_valid[j] && ent_tag[i] == ent_tag[j]));
    end
  end
endmodule

bind victim_buf vb_checker #(.ADDR_W(ADDR_W), .ENTRIES(ENTRIES)) u_vb_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_valid_i  (req_valid_i),
  .req_addr_i   (req_addr_i),
  .evict_valid_i(evict_valid_i),
  .rsp_valid_o  (rsp_valid_o),
  .rsp_hit_o    (rsp_hit_o),
  .miss_valid_o (miss_valid_o),
  .miss_addr_o  (miss_addr_o),
  .wb_valid_o   (wb_valid_o),
  .ent_valid    (ent_valid),
  .ent_tag      (ent_tag)
);

// File: tb/victim_buf_tb.sv
`timescale 1ns/1ps
module victim_buf_tb_top;
  localparam int AW = 26;
  localparam int DW = 64;
  localparam int NE = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_v = 1'b0, ev_v = 1'b0, ev_dt = 1'b0;
  logic [AW-1:0] req_a = '0, ev_a = '0;
  logic [DW-1:0] ev_d = '0;
  logic          rsp_v, rsp_h, rsp_dt, miss_v, wb_v;
  logic [DW-1:0] rsp_d, wb_d;
  logic [AW-1:0] miss_a, wb_a;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  victim_buf #(.ADDR_W(AW), .DATA_W(DW), .ENTRIES(NE)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_v), .req_addr_i(req_a),
    .evict_valid_i(ev_v), .evict_addr_i(ev_a), .evict_data_i(ev_d), .evict_dirty_i(ev_dt),
    .rsp_valid_o(rsp_v), .rsp_hit_o(rsp_h), .rsp_data_o(rsp_d), .rsp_dirty_o(rsp_dt),
    .miss_valid_o(miss_v), .miss_addr_o(miss_a),
    .wb_valid_o(wb_v), .wb_addr_o(wb_a), .wb_data_o(wb_d)
  );

  // bench reference state
  bit          m_v[NE], m_dt[NE];
  logic [AW-1:0] m_a[NE];
  logic [DW-1:0] m_d[NE];
  int          m_p = 0;

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] pool(int i);
    if (i == 9) return 26'h2000010;   // top bit differs from pool(0)
    return 26'h0000010 + AW'(i) * 26'h0040000;
  endfunction

  task automatic op(bit rv, logic [AW-1:0] ra, bit ev, logic [AW-1:0] ea,
                    logic [DW-1:0] ed, bit edt, string tag);
    bit hit = 0, dup = 0, e_wb = 0;
    int hk = 0, dk = 0;
    logic [DW-1:0] e_d = '0;
    bit e_dt = 0;
    logic [AW-1:0] e_wa = '0;
    logic [DW-1:0] e_wd = '0;
    for (int i = 0; i < NE; i++) begin
      if (rv && !hit && m_v[i] && m_a[i] == ra) begin hit = 1; hk = i; end
      if (ev && !dup && m_v[i] && m_a[i] == ea) begin dup = 1; dk = i; end
    end
    if (hit) begin e_d = m_d[hk]; e_dt = m_dt[hk]; end
    if (ev) begin
      if (dup) begin
        m_d[dk] = ed; m_dt[dk] = edt | m_dt[dk];
        if (hit && hk != dk) m_v[hk] = 0;
      end else if (hit) begin
        m_a[hk] = ea; m_d[hk] = ed; m_dt[hk] = edt;
      end else begin
        if (m_v[m_p] && m_dt[m_p]) begin e_wb = 1; e_wa = m_a[m_p]; e_wd = m_d[m_p]; end
        m_v[m_p] = 1; m_a[m_p] = ea; m_d[m_p] = ed; m_dt[m_p] = edt;
        m_p = (m_p + 1) % NE;
      end
    end else if (hit) m_v[hk] = 0;

    @(negedge clk);
    req_v = rv; req_a = ra; ev_v = ev; ev_a = ea; ev_d = ed; ev_dt = edt;
    @(posedge clk);
    #1;
    req_v = 0; ev_v = 0;
    chk({tag, "/R2"}, "rsp_valid", 64'(rsp_v), 64'(rv));
    chk({tag, "/R2"}, "rsp_hit", 64'(rsp_h), 64'(hit));
    if (hit) begin
      chk({tag, "/R2"}, "rsp_data", rsp_d, e_d);
      chk({tag, "/R2"}, "rsp_dirty", 64'(rsp_dt), 64'(e_dt));
    end
    chk({tag, "/R3"}, "miss_valid", 64'(miss_v), 64'(rv && !hit));
    if (rv && !hit) chk({tag, "/R3"}, "miss_addr", 64'(miss_a), 64'(ra));
    chk({tag, "/R6"}, "wb_valid", 64'(wb_v), 64'(e_wb));
    if (e_wb) begin
      chk({tag, "/R6"}, "wb_addr", 64'(wb_a), 64'(e_wa));
      chk({tag, "/R6"}, "wb_data", wb_d, e_wd);
    end
  endtask

  task automatic look(logic [AW-1:0] a, string tag);
    op(1, a, 0, '0, '0, 0, tag);
  endtask

  task automatic ins(logic [AW-1:0] a, logic [DW-1:0] d, bit dt, string tag);
    op(0, '0, 1, a, d, dt, tag);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    for (int i = 0; i < NE; i++) begin m_v[i] = 0; m_dt[i] = 0; m_a[i] = '0; m_d[i] = '0; end
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state at the outputs
    chk("R1", "rsp_valid", 64'(rsp_v), 0);
    chk("R1", "rsp_hit", 64'(rsp_h), 0);
    chk("R1", "miss_valid", 64'(miss_v), 0);
    chk("R1", "wb_valid", 64'(wb_v), 0);
    @(negedge clk); rst_n = 1;

    look(pool(0), "R1_empty");                 // empty buffer misses
    // R5/R8: fill slots 0..3 without lookups, clean
    for (int i = 0; i < NE; i++) ins(pool(i), 64'hA0 + 64'(i), 0, "R8_fill");
    for (int i = 0; i < NE; i++) look(pool(i), "R2_hit_all");   // frees each slot
    for (int i = 0; i < NE; i++) ins(pool(i), 64'hB0 + 64'(i), 1, "R5_dirty_fill");
    // R5/R6: overflow, pointer back at slot 0 -> pool(0) written back first
    ins(pool(4), 64'hC4, 0, "R6_overflow0");
    ins(pool(5), 64'hC5, 1, "R6_overflow1");
    look(pool(0), "R5_evicted_gone");
    // R9: top-bit alias of pool(0) misses when pool(0) stored
    ins(pool(0), 64'hD0, 0, "R9_setup");
    look(pool(9), "R9_alias");
    // R4: swap ping-pong between pool(0) and pool(9)
    op(1, pool(0), 1, pool(9), 64'hE9, 1, "R4_swap_a");
    op(1, pool(9), 1, pool(0), 64'hE0, 0, "R4_swap_b");
    look(pool(9), "R4_gone");
    // R7: eviction of an already stored address merges in place, dirty OR'd
    ins(pool(5), 64'hF5, 0, "R7_merge");
    look(pool(5), "R7_merge_check");
    ins(pool(2), 64'h12, 0, "R7_prep");
    op(1, pool(2), 1, pool(4), 64'hF4, 1, "R7_merge_with_hit");
    // R5/R6 ordering after merges and swaps
    for (int i = 6; i < 9; i++) ins(pool(i), 64'h60 + 64'(i), 1, "R5_order");
    // constrained random mix
    for (int n = 0; n < 3000; n++) begin
      bit rv = ($urandom % 4) != 0;
      bit ev = ($urandom % 3) != 0;
      op(rv, pool($urandom % 10), ev, pool($urandom % 10),
         {$urandom, $urandom}, 1'($urandom % 2), "R2_R7_random");
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule